// File: doc/BRIEF.md
# Dual Event Counter with Overflow Interrupt

This block keeps two 20-bit event counters. Each counter takes a small per-cycle event count and adds it while counting is allowed. A counter counts only if its own enable bit is set and at least one of two external qualifiers is high: a system-wide count enable or a per-process count enable. Software reaches a control word and both counters through a small register port. It can preset either counter to a start value, which sets how many events pass before the next overflow.

When a counter wraps past its top value, the part above the wrap stays in the counter. The counter's pending flag is set only if that counter's interrupt enable is on. Any pending flag drives the interrupt request. A handler clears one flag at a time with an acknowledge input and a counter index. It can then read the counter to learn how many events have arrived since the overflow.

A stored mode bit exists, but only aggregate counting (mode 0) is built. The other mode value is kept and read back, and it changes nothing else.

Top module: `dual_evt_counter`

## Requirements
- R1: After the active-low reset, both counters, the control word and both pending flags are zero, and `irq` is low.
- R2: While counter N's enable bit is set and `sysCountEn` or `procCountEn` is high, counter N increases by its event input at each clock. Counter 0 takes 0..15 per cycle and counter 1 takes 0..3 per cycle.
- R3: A counter holds its value while its enable bit is clear. Both counters hold while `sysCountEn` and `procCountEn` are both low.
- R4: A preset write stores the value if it is within the counter's ceiling and stores the ceiling otherwise. The ceiling is 0xFFFF0 for counter 0 and 0xFFFFC for counter 1. Write data bits above bit 19 count toward the out-of-range test.
- R5: A register write to a counter overrides an increment in the same cycle. That cycle raises no overflow.
- R6: When an increment carries past 0xFFFFF, the counter keeps the sum modulo 2^20. Its pending flag is set if its interrupt enable is set.
- R7: A wrap on a counter whose interrupt enable is clear leaves its pending flag and `irq` unchanged.
- R8: `irq` is high whenever at least one pending flag is set.
- R9: A cycle with `ackValid` high clears only the pending flag selected by `ackIdx` (0 or 1). `irq` falls once no flag remains.
- R10: If an acknowledge and a new overflow hit the same counter in the same cycle, the flag stays set.
- R11: Register map (read data is combinational from `regAddr`):
  - Address 0 holds the control word:
    - bit 0: counter 0 enable
    - bit 1: counter 1 enable
    - bit 2: counter 0 interrupt enable
    - bit 3: counter 1 interrupt enable
    - bit 4: mode
    - bits 9:8: read-only pending flags for counters 1:0
  - Address 1 holds counter 0 and address 2 holds counter 1, each zero-extended.
  - Address 3 reads as zero.
- R12: The mode bit is stored and read back. Setting it to 1 leaves counting the same as aggregate mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` |
| sysCountEn | input | 1 | System-wide count qualifier |
| procCountEn | input | 1 | Per-process count qualifier |
| evtCount0 | input | 4 | Events for counter 0 this cycle |
| evtCount1 | input | 2 | Events for counter 1 this cycle |
| ackValid | input | 1 | Interrupt acknowledge strobe |
| ackIdx | input | 1 | Counter whose pending flag is cleared |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a counter can only drop in value through a wrap or a preset write. They also assume that an acknowledge is the only way for `irq` to fall. Reset is the one exception, and the properties are disabled during it.

The stimulus sets the event inputs to zero before each preset write, unless a scenario deliberately collides a write with an increment. It keeps every event count within the input widths, so each cycle can wrap at most once. Acknowledges are issued only from quiet cycles, except in the one scenario that aims an acknowledge at an overflow.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int NUM_CNT = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT0 = 2'd1;
  localparam logic [1:0] ADDR_CNT1 = 2'd2;

  // Control word, packed LSB-first: cntEn[1:0], irqEn[3:2], modeSel[4]
  typedef struct packed {
    logic       modeSel;
    logic [1:0] irqEn;
    logic [1:0] cntEn;
  } ctrlReg_t;

  localparam int CTRL_W = $bits(ctrlReg_t);

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_CNT-1:0] wrCnt;
    logic [NUM_CNT-1:0] incEn;
  } dpStrobes_t;
endpackage

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 32,
  parameter int EVT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              incEn,
  input  logic [EVT_W-1:0]  evt,
  output logic [CNT_W-1:0]  cnt,
  output logic              wrap
);
  // Highest legal preset: one worst-case step below the top keeps a single wrap per cycle
  localparam logic [DATA_W-1:0] CEIL = DATA_W'((2 ** CNT_W) - (2 ** EVT_W));

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] presetVal;

  assign sum       = {1'b0, cntQ} + (CNT_W + 1)'(evt);
  assign presetVal = (wrData > CEIL) ? CEIL[CNT_W-1:0] : wrData[CNT_W-1:0];
  assign wrap      = incEn && !wrEn && sum[CNT_W];
  assign cnt       = cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cntQ <= '0;
    else if (wrEn)  cntQ <= presetVal;
    else if (incEn) cntQ <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/evc_datapath.sv
module evc_datapath
  import evc_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 32,
  parameter int EVT0_W = 4,
  parameter int EVT1_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strobes,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [EVT0_W-1:0]  evt0,
  input  logic [EVT1_W-1:0]  evt1,
  output logic [CNT_W-1:0]   cnt0,
  output logic [CNT_W-1:0]   cnt1,
  output logic [NUM_CNT-1:0] wrap
);
  localparam int EVT_MAX = (EVT0_W > EVT1_W) ? EVT0_W : EVT1_W;

  logic [NUM_CNT-1:0][EVT_MAX-1:0] evtArr;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cntArr;

  assign evtArr[0] = EVT_MAX'(evt0);
  assign evtArr[1] = EVT_MAX'(evt1);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_slice
    localparam int EW = (i == 0) ? EVT0_W : EVT1_W;
    evc_counter #(
      .CNT_W (CNT_W),
      .DATA_W(DATA_W),
      .EVT_W (EW)
    ) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .wrEn  (strobes.wrCnt[i]),
      .wrData(wrData),
      .incEn (strobes.incEn[i]),
      .evt   (evtArr[i][EW-1:0]),
      .cnt   (cntArr[i]),
      .wrap  (wrap[i])
    );
  end

  assign cnt0 = cntArr[0];
  assign cnt1 = cntArr[1];
endmodule

// File: rtl/evc_ctrl.sv
module evc_ctrl
  import evc_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic               sysCountEn,
  input  logic               procCountEn,
  input  logic               ackValid,
  input  logic               ackIdx,
  input  logic [NUM_CNT-1:0] wrap,
  input  logic [CNT_W-1:0]   cnt0,
  input  logic [CNT_W-1:0]   cnt1,
  output dpStrobes_t         strobes,
  output logic [NUM_CNT-1:0] pending,
  output logic               irq
);
  localparam int PEND_LSB = 8;

  ctrlReg_t ctrlQ;
  logic     countGate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               ctrlQ <= '0;
    else if (regWe && regAddr == ADDR_CTRL)  ctrlQ <= ctrlReg_t'(regWdata[CTRL_W-1:0]);
  end

  assign countGate = sysCountEn || procCountEn;

  always_comb begin
    strobes.wrCnt[0] = regWe && (regAddr == ADDR_CNT0);
    strobes.wrCnt[1] = regWe && (regAddr == ADDR_CNT1);
    strobes.incEn    = ctrlQ.cntEn & {NUM_CNT{countGate}};
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_pend
    localparam logic IDX = 1'(i);
    // A fresh overflow outranks an acknowledge in the same cycle
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             pending[i] <= 1'b0;
      else if (wrap[i] && ctrlQ.irqEn[i])    pending[i] <= 1'b1;
      else if (ackValid && ackIdx == IDX)    pending[i] <= 1'b0;
    end
  end

  assign irq = |pending;

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTRL: begin
        regRdata[CTRL_W-1:0]                 = ctrlQ;
        regRdata[PEND_LSB+NUM_CNT-1:PEND_LSB] = pending;
      end
      ADDR_CNT0: regRdata[CNT_W-1:0] = cnt0;
      ADDR_CNT1: regRdata[CNT_W-1:0] = cnt1;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_evt_counter.sv
module dual_evt_counter
  import evc_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 32,
  parameter int EVT0_W = 4,
  parameter int EVT1_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sysCountEn,
  input  logic              procCountEn,
  input  logic [EVT0_W-1:0] evtCount0,
  input  logic [EVT1_W-1:0] evtCount1,
  input  logic              ackValid,
  input  logic              ackIdx,
  output logic              irq
);
  dpStrobes_t         strobes;
  logic [NUM_CNT-1:0] wrap;
  logic [NUM_CNT-1:0] pending;
  logic [CNT_W-1:0]   cnt0;
  logic [CNT_W-1:0]   cnt1;

  evc_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .sysCountEn (sysCountEn),
    .procCountEn(procCountEn),
    .ackValid   (ackValid),
    .ackIdx     (ackIdx),
    .wrap       (wrap),
    .cnt0       (cnt0),
    .cnt1       (cnt1),
    .strobes    (strobes),
    .pending    (pending),
    .irq        (irq)
  );

  evc_datapath #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W),
    .EVT0_W(EVT0_W),
    .EVT1_W(EVT1_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (regWdata),
    .evt0   (evtCount0),
    .evt1   (evtCount1),
    .cnt0   (cnt0),
    .cnt1   (cnt1),
    .wrap   (wrap)
  );
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 32,
  parameter int EVT0_W = 4,
  parameter int EVT1_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              sysCountEn,
  input logic              procCountEn,
  input logic              ackValid,
  input logic              ackIdx,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  cnt1,
  input logic [1:0]        pending
);
  localparam logic [DATA_W-1:0] MAX0 = DATA_W'((2 ** CNT_W) - (2 ** EVT0_W));
  localparam logic [DATA_W-1:0] MAX1 = DATA_W'((2 ** CNT_W) - (2 ** EVT1_W));

  // R3: with both qualifiers low and no write, neither counter moves
  p_gate_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!sysCountEn && !procCountEn && !regWe) |=> ($stable(cnt0) && $stable(cnt1)));

  // R4: a preset never lands above the ceiling
  p_ceiling0_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd1) |=> (DATA_W'(cnt0) <= MAX0));
  p_ceiling1_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd2) |=> (DATA_W'(cnt1) <= MAX1));

  // R5: an in-range write lands exactly, whatever the events
  p_write_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd1 && regWdata <= MAX0) |=> (cnt0 == $past(regWdata[CNT_W-1:0])));

  // R6: a pending flag only rises on a wrap
  p_pend_on_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending[0]) |-> (cnt0 < $past(cnt0)));

  // R9: acknowledge clears flag 0 unless it re-overflowed
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !ackIdx) |=> (!pending[0] || (cnt0 < $past(cnt0))));

  // R9: irq only falls after an acknowledge
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(ackValid));
endmodule

bind dual_evt_counter evc_checker #(
  .CNT_W (CNT_W),
  .DATA_W(DATA_W),
  .EVT0_W(EVT0_W),
  .EVT1_W(EVT1_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWe      (regWe),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .sysCountEn (sysCountEn),
  .procCountEn(procCountEn),
  .ackValid   (ackValid),
  .ackIdx     (ackIdx),
  .irq        (irq),
  .cnt0       (cnt0),
  .cnt1       (cnt1),
  .pending    (pending)
);

// File: tb/dual_evt_counter_tb_top.sv
`timescale 1ns/1ps
module dual_evt_counter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sysCountEn = 1'b0;
  logic        procCountEn = 1'b0;
  logic [3:0]  evtCount0 = '0;
  logic [1:0]  evtCount1 = '0;
  logic        ackValid = 1'b0;
  logic        ackIdx = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dual_evt_counter dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sysCountEn(sysCountEn),
    .procCountEn(procCountEn), .evtCount0(evtCount0), .evtCount1(evtCount1),
    .ackValid(ackValid), .ackIdx(ackIdx), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    readReg(2'd0, v); check("R1 ctrl", v, 32'h0);
    readReg(2'd1, v); check("R1 cnt0", v, 32'h0);
    readReg(2'd2, v); check("R1 cnt1", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    writeReg(2'd0, 32'h3);
    sysCountEn = 1; evtCount0 = 5; evtCount1 = 3;
    tick(4);
    evtCount0 = 0; evtCount1 = 0;
    readReg(2'd1, v); check("R2 cnt0 sys", v, 32'd20);
    readReg(2'd2, v); check("R2 cnt1 sys", v, 32'd12);
    sysCountEn = 0; procCountEn = 1; evtCount0 = 1;
    tick(2);
    evtCount0 = 0;
    readReg(2'd1, v); check("R2 cnt0 proc", v, 32'd22);
    procCountEn = 0;
  endtask

  task automatic t_gate;
    logic [31:0] v;
    evtCount0 = 15; evtCount1 = 3;
    tick(3);
    evtCount0 = 0; evtCount1 = 0;
    readReg(2'd1, v); check("R3 cnt0 no qualifier", v, 32'd22);
    readReg(2'd2, v); check("R3 cnt1 no qualifier", v, 32'd12);
    writeReg(2'd0, 32'h2);
    sysCountEn = 1; evtCount0 = 9; evtCount1 = 1;
    tick(2);
    evtCount0 = 0; evtCount1 = 0; sysCountEn = 0;
    readReg(2'd1, v); check("R3 cnt0 own enable off", v, 32'd22);
    readReg(2'd2, v); check("R3 cnt1 still counts", v, 32'd14);
  endtask

  task automatic t_clamp;
    logic [31:0] v;
    writeReg(2'd1, 32'h000FFFFF);
    readReg(2'd1, v); check("R4 cnt0 clamp", v, 32'hFFFF0);
    writeReg(2'd2, 32'h00123456);
    readReg(2'd2, v); check("R4 cnt1 clamp wide", v, 32'hFFFFC);
    writeReg(2'd1, 32'h00000ABC);
    readReg(2'd1, v); check("R4 cnt0 in range", v, 32'hABC);
    writeReg(2'd2, 32'h000FFFFC);
    readReg(2'd2, v); check("R4 cnt1 at ceiling", v, 32'hFFFFC);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    writeReg(2'd0, 32'h1);
    sysCountEn = 1; evtCount0 = 7;
    writeReg(2'd1, 32'd100);
    readReg(2'd1, v); check("R5 write beats increment", v, 32'd100);
    tick();
    evtCount0 = 0; sysCountEn = 0;
    readReg(2'd1, v); check("R5 count resumes", v, 32'd107);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    writeReg(2'd0, 32'h5);
    writeReg(2'd1, 32'hFFFF0);
    sysCountEn = 1; evtCount0 = 15;
    tick();
    evtCount0 = 0;
    readReg(2'd1, v); check("R6 top no wrap", v, 32'hFFFFF);
    check("R8 irq low before wrap", {31'b0, irq}, 32'h0);
    evtCount0 = 3;
    tick();
    evtCount0 = 0;
    readReg(2'd1, v); check("R6 residue kept", v, 32'h2);
    readReg(2'd0, v); check("R6 pending0 set", v, 32'h105);
    check("R8 irq raised", {31'b0, irq}, 32'h1);
    sysCountEn = 0;
  endtask

  task automatic t_ack;
    logic [31:0] v;
    ackValid = 1; ackIdx = 1;
    tick();
    ackValid = 0;
    readReg(2'd0, v); check("R9 other index keeps flag", v, 32'h105);
    check("R9 irq kept", {31'b0, irq}, 32'h1);
    ackValid = 1; ackIdx = 0;
    tick();
    ackValid = 0;
    readReg(2'd0, v); check("R9 flag cleared", v, 32'h005);
    check("R9 irq falls", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_noie;
    logic [31:0] v;
    writeReg(2'd0, 32'h2);
    writeReg(2'd2, 32'hFFFFC);
    sysCountEn = 1; evtCount1 = 3;
    tick();
    evtCount1 = 2;
    tick();
    evtCount1 = 0; sysCountEn = 0;
    readReg(2'd2, v); check("R7 cnt1 wrapped", v, 32'h1);
    readReg(2'd0, v); check("R7 no pending", v, 32'h002);
    check("R7 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    writeReg(2'd0, 32'hF);
    writeReg(2'd2, 32'hFFFFC);
    writeReg(2'd1, 32'hFFFF0);
    sysCountEn = 1; evtCount1 = 3;
    tick();
    evtCount1 = 1; ackValid = 1; ackIdx = 1;
    tick();
    evtCount1 = 0; ackValid = 0;
    readReg(2'd0, v); check("R10 overflow beats ack", v, 32'h20F);
    evtCount0 = 15;
    tick(2);
    evtCount0 = 0; sysCountEn = 0;
    readReg(2'd0, v); check("R8 both pending", v, 32'h30F);
    ackValid = 1; ackIdx = 0;
    tick();
    ackValid = 0;
    check("R8 irq held by other flag", {31'b0, irq}, 32'h1);
    ackValid = 1; ackIdx = 1;
    tick();
    ackValid = 0;
    check("R9 irq clear after both acks", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mode;
    logic [31:0] v;
    writeReg(2'd0, 32'h13);
    readReg(2'd0, v); check("R12 mode readback", v, 32'h13);
    readReg(2'd3, v); check("R11 unused address", v, 32'h0);
    writeReg(2'd1, 32'd40);
    procCountEn = 1; evtCount0 = 2;
    tick();
    evtCount0 = 0; procCountEn = 0;
    readReg(2'd1, v); check("R12 counting unchanged by mode", v, 32'd42);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick();
    t_reset();
    t_count();
    t_gate();
    t_clamp();
    t_priority();
    t_wrap();
    t_ack();
    t_noie();
    t_collide();
    t_mode();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule